// File: doc/BRIEF.md
# Endian-Selectable Byte-Addressed Load/Store Port

This block is a byte-organised storage array behind one access port. On every clock the port performs one access of one, two or four bytes. The access starts at any byte address Z and covers the bytes Z, Z+1, ... up to the access width. Alignment is not required. A per-access mode bit chooses how those consecutive bytes map onto the lanes of the 32-bit data word:

- In big-endian order the byte at Z becomes the most significant byte of the value.
- In little-endian order the byte at Z becomes the least significant byte.

Reordering always moves whole bytes.

Reads are registered. The read word for an access appears one cycle after the access, zero-extended for narrow sizes, and it reflects the contents before any write made in the same cycle. A write changes only the bytes that the access covers. An access whose last byte would lie past the end of the array writes nothing, returns zero and raises the error output. The size code 3 is reserved: it does nothing and raises no error.

A small state register records the outcome of the most recent access and drives the error output:

- `ST_IDLE`: no access since reset.
- `ST_LOAD`: legal access without a write.
- `ST_STORE`: legal access with a write.
- `ST_RSVD`: reserved size code.
- `ST_FAULT`: range violation.

Every state moves on each clock to the state given by the current access. Reserved beats range, range beats the write decision, and the write decision selects `ST_STORE` over `ST_LOAD`. Reset returns to `ST_IDLE`.

Top module: `endian_mem_port`

## Requirements
- R1: While and after reset, `rdata` is 0 and `err` is 0, and every byte of the array reads as 0 until written.
- R2: Size code 2'b00 accesses the single byte at `addr`; a read returns it in `rdata[7:0]` with `rdata[31:8]` zero.
- R3: Size code 2'b01 covers bytes Z and Z+1 and returns them in `rdata[15:0]` with the upper half zero; with `big_end`=1 byte Z is `rdata[15:8]`.
- R4: With `big_end`=0 the byte at Z is the least significant byte of the value (`rdata[7:0]`), for both 16- and 32-bit sizes.
- R5: Size code 2'b10 covers Z..Z+3; bytes 02,04,06,08 at 0x200..0x203 read as 0x02040608 with `big_end`=1 and 0x08060402 with `big_end`=0.
- R6: A write (`wr_en`=1) stores the lanes of `wdata` into exactly the bytes covered by the access, using the same byte-to-lane mapping as a read; bytes outside the access keep their values.
- R7: Size code 2'b11 is reserved: nothing is written, `rdata` becomes 0 and `err` stays 0 on the next cycle.
- R8: If Z plus the access width exceeds DEPTH, nothing is written, and on the next cycle `err` is 1 and `rdata` is 0; an access ending exactly at the last byte is legal.
- R9: `rdata` and `err` update one clock after the access. A read in the same cycle as a write to the same bytes returns the contents before that write.
- R10: The byte order is chosen per access, and unaligned addresses of every size work in both orders.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | ADDR_W | Byte address Z of the first byte of the access |
| size | input | 2 | Access width code: 0 byte, 1 two bytes, 2 four bytes, 3 reserved |
| big_end | input | 1 | 1 = byte Z is most significant, 0 = byte Z is least significant |
| wr_en | input | 1 | 1 = write `wdata` into the covered bytes |
| wdata | input | 32 | Write value, right-aligned for narrow sizes |
| rdata | output | 32 | Registered, zero-extended read value |
| err | output | 1 | Registered range-violation flag for the previous access |

## Verification
The fixed pattern 02,04,06,08 is read at every width in both byte orders. This separates whole-byte swapping from digit swapping, and it shows whether a 16-bit read wrongly pulls in bytes Z+2 and Z+3. Narrow and unaligned writes are followed by reads of the neighbouring bytes, which exposes lane enables that spill over the access. Accesses ending exactly at the last byte, and one byte past it, pin down the range comparison. A same-cycle write and read of one word shows read-before-write ordering. A long pseudo-random mix of addresses, sizes, orders and write flags, including reserved codes, is compared against a behavioural byte-array model on every clock.

// File: rtl/endian_port_pkg.sv
package endian_port_pkg;

    localparam int LANES = 4;
    localparam int DATA_W = LANES * 8;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'b00,
        SZ_HALF = 2'b01,
        SZ_WORD = 2'b10,
        SZ_RSVD = 2'b11
    } size_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LOAD,
        ST_STORE,
        ST_RSVD,
        ST_FAULT
    } port_state_e;

    function automatic logic [2:0] size_bytes(input logic [1:0] code);
        logic [2:0] n;
        unique case (code)
            2'b00:   n = 3'd1;
            2'b01:   n = 3'd2;
            2'b10:   n = 3'd4;
            default: n = 3'd0;
        endcase
        return n;
    endfunction

endpackage

// File: rtl/endian_lane_map.sv
module endian_lane_map
    import endian_port_pkg::*;
(
    input  logic [1:0]         size,
    input  logic               big_end,
    output logic [LANES-1:0]   pos_valid,
    output logic [LANES*2-1:0] pos_lane
);

    logic [2:0] nb;
    assign nb = size_bytes(size);

    // Byte at Z+i lands in lane i (little order) or lane nb-1-i (big order).
    for (genvar i = 0; i < LANES; i++) begin : g_pos
        assign pos_valid[i]      = (3'(i) < nb);
        assign pos_lane[i*2 +: 2] = big_end ? 2'(nb - 3'(i) - 3'd1) : 2'(i);
    end

endmodule

// File: rtl/endian_byte_store.sv
module endian_byte_store
    import endian_port_pkg::*;
#(
    parameter int unsigned DEPTH  = 1000,
    parameter int unsigned ADDR_W = 10
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [ADDR_W-1:0]  base,
    input  logic [LANES-1:0]   we,
    input  logic [DATA_W-1:0]  wbytes,
    output logic [DATA_W-1:0]  rbytes
);

    localparam int IW = ADDR_W + 2;

    logic [7:0]    mem [DEPTH];
    logic [IW-1:0] idx [LANES];

    for (genvar p = 0; p < LANES; p++) begin : g_port
        assign idx[p] = IW'(base) + IW'(p);
        assign rbytes[p*8 +: 8] = (idx[p] < IW'(DEPTH)) ? mem[idx[p][ADDR_W-1:0]] : 8'h00;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int k = 0; k < int'(DEPTH); k++) begin
                mem[k] <= 8'h00;
            end
        end else begin
            for (int p = 0; p < LANES; p++) begin
                if (we[p]) begin
                    mem[idx[p][ADDR_W-1:0]] <= wbytes[p*8 +: 8];
                end
            end
        end
    end

    // R6: enabled positions always form a run starting at the base byte
    assert_lanes_contiguous_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (we == 4'b0000) || (we == 4'b0001) || (we == 4'b0011) || (we == 4'b1111));

    // R8: no enabled position ever points past the array
    assert_store_in_range_R8: assert property (@(posedge clk) disable iff (!rst_n)
        we[LANES-1] |-> (idx[LANES-1] < IW'(DEPTH)));

endmodule

// File: rtl/endian_mem_port.sv
module endian_mem_port
    import endian_port_pkg::*;
#(
    parameter int unsigned DEPTH  = 1000,
    parameter int unsigned ADDR_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [1:0]        size,
    input  logic              big_end,
    input  logic              wr_en,
    input  logic [31:0]       wdata,
    output logic [31:0]       rdata,
    output logic              err
);

    localparam int EW = ADDR_W + 1;
    localparam logic [EW-1:0] LIMIT = EW'(DEPTH);

    size_e              sz;
    logic [LANES-1:0]   pos_valid;
    logic [LANES*2-1:0] pos_lane;
    logic [2:0]         nb;
    logic [EW-1:0]      end_excl;
    logic               over;
    logic               rsvd;
    logic               legal;
    logic [LANES-1:0]   store_we;
    logic [DATA_W-1:0]  store_w;
    logic [DATA_W-1:0]  store_r;
    logic [DATA_W-1:0]  rd_next;
    port_state_e        state, state_nx;

    assign sz       = size_e'(size);
    assign nb       = size_bytes(size);
    assign end_excl = EW'(addr) + EW'(nb);
    assign rsvd     = (sz == SZ_RSVD);
    assign over     = !rsvd && (end_excl > LIMIT);
    assign legal    = !rsvd && !over;
    assign store_we = pos_valid & {LANES{wr_en && legal}};

    endian_lane_map u_map (
        .size     (size),
        .big_end  (big_end),
        .pos_valid(pos_valid),
        .pos_lane (pos_lane)
    );

    for (genvar i = 0; i < LANES; i++) begin : g_wsplit
        assign store_w[i*8 +: 8] = wdata[{pos_lane[i*2 +: 2], 3'b000} +: 8];
    end

    endian_byte_store #(
        .DEPTH (DEPTH),
        .ADDR_W(ADDR_W)
    ) u_store (
        .clk   (clk),
        .rst_n (rst_n),
        .base  (addr),
        .we    (store_we),
        .wbytes(store_w),
        .rbytes(store_r)
    );

    always_comb begin
        rd_next = '0;
        for (int p = 0; p < LANES; p++) begin
            if (pos_valid[p] && legal) begin
                rd_next[{pos_lane[p*2 +: 2], 3'b000} +: 8] = store_r[p*8 +: 8];
            end
        end
    end

    always_comb begin
        if (rsvd)       state_nx = ST_RSVD;
        else if (over)  state_nx = ST_FAULT;
        else if (wr_en) state_nx = ST_STORE;
        else            state_nx = ST_LOAD;
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // registered read word
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rdata <= '0;
        else        rdata <= rd_next;
    end

    // outputs decoded from the state
    always_comb begin
        unique case (state)
            ST_IDLE:  err = 1'b0;
            ST_LOAD:  err = 1'b0;
            ST_STORE: err = 1'b0;
            ST_RSVD:  err = 1'b0;
            ST_FAULT: err = 1'b1;
            default:  err = 1'b0;
        endcase
    end

    assert_fault_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_FAULT) |-> (rdata == '0));

    assert_rsvd_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RSVD) |-> ((rdata == '0) && !err));

    assert_byte_zext_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (size == 2'b00) |=> (rdata[31:8] == 24'h0));

    assert_half_zext_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (size == 2'b01) |=> (rdata[31:16] == 16'h0));

endmodule

// File: tb/endian_mem_port_bench.sv
module endian_mem_port_bench;

    localparam int DEPTH = 1000;
    localparam int AW    = 10;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [1:0]    size = 2'b00;
    logic          big_end = 1'b0;
    logic          wr_en = 1'b0;
    logic [31:0]   wdata = '0;
    logic [31:0]   rdata;
    logic          err;

    int  checks = 0;
    int  errors = 0;
    bit  done = 0;
    byte unsigned model [DEPTH];

    always #2 clk = ~clk;

    endian_mem_port #(.DEPTH(DEPTH), .ADDR_W(AW)) u_endian_mem_port (
        .clk(clk), .rst_n(rst_n), .addr(addr), .size(size), .big_end(big_end),
        .wr_en(wr_en), .wdata(wdata), .rdata(rdata), .err(err)
    );

    task automatic check(input string tag, input logic [31:0] exp_d, input logic exp_e);
        checks++;
        if (rdata !== exp_d || err !== exp_e) begin
            errors++;
            $display("FAIL %s: rdata=%h err=%b expected rdata=%h err=%b",
                     tag, rdata, err, exp_d, exp_e);
        end
    endtask

    // one access; the model gives the value expected one clock later
    task automatic acc(input string tag, input int a, input logic [1:0] s,
                       input logic be, input logic we, input logic [31:0] wd);
        int n;
        logic [31:0] exp_d;
        logic exp_e;
        @(negedge clk);
        addr = AW'(a); size = s; big_end = be; wr_en = we; wdata = wd;
        n = (s == 2'b00) ? 1 : (s == 2'b01) ? 2 : (s == 2'b10) ? 4 : 0;
        exp_d = '0;
        exp_e = 1'b0;
        if (n != 0) begin
            if (a + n > DEPTH) begin
                exp_e = 1'b1;
            end else begin
                for (int i = 0; i < n; i++) begin
                    int lane = be ? (n - 1 - i) : i;
                    exp_d[lane*8 +: 8] = model[a+i];
                end
                if (we) begin
                    for (int i = 0; i < n; i++) begin
                        int lane = be ? (n - 1 - i) : i;
                        model[a+i] = wd[lane*8 +: 8];
                    end
                end
            end
        end
        @(posedge clk);
        #1;
        check(tag, exp_d, exp_e);
    endtask

    initial begin
        #(4 * 100000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        for (int k = 0; k < DEPTH; k++) model[k] = 8'h00;
        repeat (3) @(posedge clk);
        #1;
        check("R1 reset value", 32'h0, 1'b0);
        @(negedge clk);
        rst_n = 1'b1;

        acc("R1 fresh array reads zero", 300, 2'b10, 1'b1, 1'b0, 32'h0);
        acc("R2 byte write 0x200", 'h200, 2'b00, 1'b0, 1'b1, 32'hFFFF_FF02);
        acc("R2 byte write 0x201", 'h201, 2'b00, 1'b1, 1'b1, 32'h0000_0004);
        acc("R2 byte write 0x202", 'h202, 2'b00, 1'b0, 1'b1, 32'h1234_5606);
        acc("R2 byte write 0x203", 'h203, 2'b00, 1'b1, 1'b1, 32'h0000_0008);
        acc("R2 byte read 0x202", 'h202, 2'b00, 1'b1, 1'b0, 32'h0);
        acc("R5 word big order", 'h200, 2'b10, 1'b1, 1'b0, 32'h0);
        acc("R5 word little order", 'h200, 2'b10, 1'b0, 1'b0, 32'h0);
        acc("R3 half big order", 'h200, 2'b01, 1'b1, 1'b0, 32'h0);
        acc("R4 half little order", 'h200, 2'b01, 1'b0, 1'b0, 32'h0);

        acc("R6 half write little 0x101", 'h101, 2'b01, 1'b0, 1'b1, 32'hAABB_1234);
        acc("R6 neighbour 0x100", 'h100, 2'b00, 1'b0, 1'b0, 32'h0);
        acc("R6 neighbour 0x103", 'h103, 2'b00, 1'b0, 1'b0, 32'h0);
        acc("R6 half readback big", 'h101, 2'b01, 1'b1, 1'b0, 32'h0);
        acc("R10 unaligned word write big", 'h0F1, 2'b10, 1'b1, 1'b1, 32'hDEAD_BEEF);
        acc("R10 unaligned word read little", 'h0F1, 2'b10, 1'b0, 1'b0, 32'h0);
        acc("R10 half inside word little", 'h0F2, 2'b01, 1'b0, 1'b0, 32'h0);
        acc("R6 neighbour 0x0F5", 'h0F5, 2'b00, 1'b0, 1'b0, 32'h0);

        acc("R7 reserved with write", 'h200, 2'b11, 1'b1, 1'b1, 32'hFFFF_FFFF);
        acc("R7 contents unchanged", 'h200, 2'b10, 1'b1, 1'b0, 32'h0);

        acc("R8 word at last legal address", 996, 2'b10, 1'b0, 1'b1, 32'h4433_2211);
        acc("R8 word one past end", 997, 2'b10, 1'b0, 1'b1, 32'hFFFF_FFFF);
        acc("R8 half past end", 999, 2'b01, 1'b1, 1'b1, 32'h0000_FFFF);
        acc("R8 last byte legal", 999, 2'b00, 1'b0, 1'b0, 32'h0);
        acc("R8 faulted writes left no trace", 996, 2'b10, 1'b0, 1'b0, 32'h0);

        acc("R9 write returns old value", 'h200, 2'b10, 1'b1, 1'b1, 32'hCAFE_F00D);
        acc("R9 next read sees new value", 'h200, 2'b10, 1'b1, 1'b0, 32'h0);

        begin
            logic [31:0] seed = 32'h1357_9BDF;
            for (int t = 0; t < 400; t++) begin
                int a;
                seed = seed * 32'd1664525 + 32'd1013904223;
                a = (seed[20]) ? int'(seed[31:22]) % 16 + 990 : int'(seed[31:22]) % 64 + 'h1F0;
                acc("R10 mixed traffic", a, seed[9:8], seed[11], seed[13], seed ^ 32'h5A5A_A5A5);
            end
        end

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule